// File: doc/BRIEF.md
# Queue Congestion Watermark Monitor

This block watches the fill level of one packet queue and measures how often and for how long that level sits above a programmable watermark. Every clock cycle it samples the current depth. It counts each move from at-or-below the watermark to above it as one congestion event. It also accumulates the time spent above the watermark, in units of a programmable number of clock cycles. A chip places one instance on the inbound side of a port and another on the outbound side, and each instance is configured on its own.

When the event count passes a programmable limit, the block latches an alert. The alert drives a level interrupt and a one-cycle notification-request strobe, and each of the two outputs has its own enable. Software reaches the settings and the counters through a plain register port. The read data is combinational and valid while the read strobe is high. Reading a counter returns its value and clears it at the same clock edge.

The depth input is a plain sample taken every cycle, not a stream, so the block has no valid/ready handshake and applies no back-pressure. The register strobes are single-cycle and always accepted.

Top module: `qwm_monitor`

## Requirements
- R1: After reset, the watermark reads 0x3FF, the limit reads all ones (CNT_W bits), the prescale reads 1, the control register reads 0, both counters and the status register read 0, and irq and notify_req are low.
- R2: The event counter (address 4) goes up by one at each clock edge where q_depth is above the watermark and was at or below it at the previous edge. Depth that stays above, or that equals the watermark, adds nothing.
- R3: While depth stays above the watermark, the period counter (address 5) goes up by one for every N consecutive above-watermark cycles, where N is the prescale value (address 2, 16 bits). A prescale of 0 behaves as 1.
- R4: A cycle with depth at or below the watermark discards any partial prescale interval, so the cycles of separate episodes never add up to one period increment.
- R5: Both counters stop at 2^CNT_W-1 instead of wrapping.
- R6: A read of a counter address returns the value held before the edge and clears the counter at that edge. If an increment falls in the same cycle, the counter holds 1 after the edge.
- R7: The alert flag (status address 6, bit 0) sets one cycle after the event count first exceeds the limit (address 1). irq equals alert AND control bit 0. Reading the event counter, or writing 1 to status bit 0, clears the alert at that edge. The alert sets again if the count still exceeds the limit.
- R8: notify_req pulses high for exactly one cycle, in the cycle after the alert goes from clear to set, provided control bit 1 is set.
- R9: The configuration registers read back what was written, with unused bits reading 0: watermark at address 0 (bits 9:0), limit at address 1 (CNT_W bits), prescale at address 2 (bits 15:0), control at address 3 (bit 0 irq enable, bit 1 notify enable).
- R10: Writes to the counter addresses have no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_depth | input | DEPTH_W | Current queue occupancy, sampled every cycle |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rd | input | 1 | Register read strobe; a read clears the addressed counter |
| reg_rdata | output | DATA_W | Read data, combinational, zero when reg_rd is low |
| irq | output | 1 | Level interrupt, alert gated by enable |
| notify_req | output | 1 | One-cycle notification request strobe |

## Verification
Two things can fall in the same cycle: a software read that clears a counter, and a depth crossing that increments that counter. The bench provokes this by raising the depth above the watermark in the same cycle as a read of the event counter. The check passes when the read returns the old count and a second read returns exactly 1. A second collision comes from a write-1-to-clear of the alert while the event count still exceeds the limit. That case is judged by seeing irq drop for one cycle and then set again, and by seeing it stay low once the counter itself has been read.

// File: rtl/qwm_pkg.sv
package qwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_WMARK    = 3'd0,
    RA_LIMIT    = 3'd1,
    RA_PRESCALE = 3'd2,
    RA_CTRL     = 3'd3,
    RA_EVENTS   = 3'd4,
    RA_PERIOD   = 3'd5,
    RA_STATUS   = 3'd6,
    RA_SPARE    = 3'd7
  } reg_addr_e;

  localparam int NUM_CNT = 2;
  localparam int CNT_EVENTS = 0;
  localparam int CNT_PERIOD = 1;
endpackage

// File: rtl/qwm_edge_detect.sv
module qwm_edge_detect #(
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [DEPTH_W-1:0] wmark,
  output logic               above,
  output logic               rise
);
  logic above_q;

  assign above = depth > wmark;
  assign rise  = above && !above_q;

  always_ff @(posedge clk) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above;
  end
endmodule

// File: rtl/qwm_prescaler.sv
module qwm_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PRE_W-1:0] interval,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] span;

  assign span = (interval == '0) ? PRE_W'(1) : interval;
  assign tick = active && (phase_q >= span - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (!active) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + PRE_W'(1);
  end

  // R4: a below-watermark cycle leaves no partial interval behind
  p_phase_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (phase_q == '0));
endmodule

// File: rtl/qwm_sat_counter.sv
module qwm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= inc ? W'(1) : '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !clr) |=> (cnt == TOP));
  p_clear_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt <= W'(1)));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/qwm_monitor.sv
module qwm_monitor
  import qwm_pkg::*;
#(
  parameter int DEPTH_W = 10,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] q_depth,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rd,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               notify_req
);
  reg_addr_e addr_e;
  assign addr_e = reg_addr_e'(reg_addr);

  logic [DEPTH_W-1:0] wmark_q;
  logic [CNT_W-1:0]   limit_q;
  logic [PRE_W-1:0]   pre_q;
  logic               irq_en_q, notify_en_q;
  logic               alert_q, notify_q;

  logic               above, rise, tick;
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic               over_limit, alert_clr, status_w1c;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmark_q     <= '1;
      limit_q     <= '1;
      pre_q       <= PRE_W'(1);
      irq_en_q    <= 1'b0;
      notify_en_q <= 1'b0;
    end else if (reg_wr) begin
      case (addr_e)
        RA_WMARK:    wmark_q <= reg_wdata[DEPTH_W-1:0];
        RA_LIMIT:    limit_q <= reg_wdata[CNT_W-1:0];
        RA_PRESCALE: pre_q   <= reg_wdata[PRE_W-1:0];
        RA_CTRL: begin
          irq_en_q    <= reg_wdata[0];
          notify_en_q <= reg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  qwm_edge_detect #(.DEPTH_W(DEPTH_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .depth(q_depth), .wmark(wmark_q),
    .above(above), .rise(rise)
  );

  qwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(above), .interval(pre_q), .tick(tick)
  );

  assign cnt_inc[CNT_EVENTS] = rise;
  assign cnt_inc[CNT_PERIOD] = tick;
  assign cnt_clr[CNT_EVENTS] = reg_rd && (addr_e == RA_EVENTS);
  assign cnt_clr[CNT_PERIOD] = reg_rd && (addr_e == RA_PERIOD);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    qwm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[i]), .clr(cnt_clr[i]),
      .cnt(cnt_val[i])
    );
  end

  // alert latch and notification strobe
  assign status_w1c = reg_wr && (addr_e == RA_STATUS) && reg_wdata[0];
  assign alert_clr  = cnt_clr[CNT_EVENTS] || status_w1c;
  assign over_limit = cnt_val[CNT_EVENTS] > limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alert_q  <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      if (alert_clr)       alert_q <= 1'b0;
      else if (over_limit) alert_q <= 1'b1;
      notify_q <= notify_en_q && !alert_clr && over_limit && !alert_q;
    end
  end

  assign irq        = alert_q && irq_en_q;
  assign notify_req = notify_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (addr_e)
        RA_WMARK:    reg_rdata = DATA_W'(wmark_q);
        RA_LIMIT:    reg_rdata = DATA_W'(limit_q);
        RA_PRESCALE: reg_rdata = DATA_W'(pre_q);
        RA_CTRL:     reg_rdata = DATA_W'({notify_en_q, irq_en_q});
        RA_EVENTS:   reg_rdata = DATA_W'(cnt_val[CNT_EVENTS]);
        RA_PERIOD:   reg_rdata = DATA_W'(cnt_val[CNT_PERIOD]);
        RA_STATUS:   reg_rdata = DATA_W'(alert_q);
        default:     reg_rdata = '0;
      endcase
    end
  end

  p_rise_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt_val[CNT_EVENTS] != '0));
  p_clear_drops_alert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |=> !alert_q);
  p_notify_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |=> !notify_req);
  p_notify_with_alert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |-> alert_q);
endmodule

// File: tb/qwm_monitor_test.sv
`timescale 1ns/1ps
module qwm_monitor_test;
  localparam int CW = 6;
  localparam logic [2:0] A_WM = 3'd0, A_LIM = 3'd1, A_PRE = 3'd2, A_CTL = 3'd3,
                         A_EV = 3'd4, A_PER = 3'd5, A_ST = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  q_depth = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, notify_req;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  qwm_monitor #(.DEPTH_W(10), .CNT_W(CW), .PRE_W(16), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .q_depth(q_depth), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq(irq), .notify_req(notify_req)
  );

  // rows: {depth, cycles above, expected events, expected period}; wmark 100, prescale 3
  localparam logic [31:0] VEC [8] = '{
    {10'd150, 8'd7, 6'd1, 8'd2}, {10'd100, 8'd5, 6'd0, 8'd0},
    {10'd101, 8'd3, 6'd1, 8'd1}, {10'd101, 8'd2, 6'd1, 8'd0},
    {10'd1023, 8'd9, 6'd1, 8'd3}, {10'd50, 8'd4, 6'd0, 8'd0},
    {10'd101, 8'd1, 6'd1, 8'd0}, {10'd400, 8'd6, 6'd1, 8'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic [9:0] d, input int n);
    q_depth = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 notify", notify_req, 0);
    rd(A_WM, v);  check("R1 wmark", v, 32'h3FF);
    rd(A_LIM, v); check("R1 limit", v, 32'h3F);
    rd(A_PRE, v); check("R1 prescale", v, 1);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(A_EV, v);  check("R1 events", v, 0);
    rd(A_PER, v); check("R1 period", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);

    // R9 read back with unused bits zero
    wr(A_WM, 32'hFFFF_FFFF);  rd(A_WM, v);  check("R9 wmark", v, 32'h3FF);
    wr(A_LIM, 32'hFFFF_FF25); rd(A_LIM, v); check("R9 limit", v, 32'h25);
    wr(A_PRE, 32'hABCD_1234); rd(A_PRE, v); check("R9 prescale", v, 32'h1234);
    wr(A_CTL, 32'hFFFF_FFFE); rd(A_CTL, v); check("R9 ctrl", v, 32'h2);
    wr(A_CTL, 0);

    // R10 writes to counters ignored
    wr(A_EV, 32'h15); wr(A_PER, 32'h15);
    rd(A_EV, v);  check("R10 events", v, 0);
    rd(A_PER, v); check("R10 period", v, 0);

    // vector table: R2/R3
    wr(A_WM, 100); wr(A_PRE, 3); wr(A_LIM, 32'h3F);
    for (int i = 0; i < 8; i++) begin
      hold(VEC[i][31:22], int'(VEC[i][21:14]));
      hold(0, 1);
      rd(A_EV, v);  check("R2 table events", v, 32'(VEC[i][13:8]));
      rd(A_PER, v); check("R3 table period", v, 32'(VEC[i][7:0]));
    end

    // R3 prescale 0 acts as 1
    wr(A_PRE, 0);
    hold(200, 4); hold(0, 1);
    rd(A_PER, v); check("R3 prescale0 period", v, 4);
    rd(A_EV, v);  check("R2 single episode", v, 1);

    // R4 partial intervals dropped; R2 two crossings
    wr(A_PRE, 3);
    hold(200, 2); hold(0, 1); hold(200, 2); hold(0, 1);
    rd(A_PER, v); check("R4 no carry", v, 0);
    rd(A_EV, v);  check("R2 two crossings", v, 2);

    // R5 saturation
    wr(A_PRE, 1);
    for (int i = 0; i < 70; i++) begin hold(200, 1); hold(0, 1); end
    rd(A_EV, v);  check("R5 events sat", v, 63);
    rd(A_PER, v); check("R5 period sat", v, 63);

    // R6 read-clear colliding with increment
    hold(200, 1); hold(0, 1);
    q_depth = 200;
    rd(A_EV, v);  check("R6 old value", v, 1);
    hold(0, 1);
    rd(A_EV, v);  check("R6 restart at 1", v, 1);
    rd(A_PER, v);

    // R7/R8 alert path
    wr(A_LIM, 1); wr(A_CTL, 3);
    hold(200, 1); hold(0, 1);
    check("R7 below limit", irq, 0);
    hold(200, 1); hold(0, 1);
    check("R7 irq set", irq, 1);
    check("R8 notify pulse", notify_req, 1);
    hold(0, 1);
    check("R8 notify one cycle", notify_req, 0);
    check("R7 irq level", irq, 1);
    rd(A_ST, v); check("R7 status bit", v, 1);
    wr(A_CTL, 2); check("R7 irq gated", irq, 0);
    wr(A_CTL, 3); check("R7 irq regated", irq, 1);
    wr(A_ST, 1);  check("R7 w1c clears", irq, 0);
    hold(0, 1);   check("R7 re-set while over", irq, 1);
    rd(A_EV, v);  check("R7 event count", v, 2);
    check("R7 read clears", irq, 0);
    hold(0, 2);   check("R7 stays clear", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule